// File: doc/BRIEF.md
# Ultra DMA Data-In Burst Receiver

This block is the host end of an Ultra DMA read burst. The device raises its request. The receiver then takes the acknowledge, holds it for an envelope interval, and opens the burst: the stop line is released and the ready line is raised in the same cycle. From then on, every edge of the device strobe, rising or falling, carries one 16-bit word. Each word goes into an internal store and then leaves on a valid/ready output stream.

When the store runs short of room, the receiver drops its ready line. It keeps taking every word that is still in flight. Only after the ready-to-pause interval for the current mode has passed does it flag the sender as paused. When room returns, it raises ready again.

A one-cycle end request closes the burst: ready is dropped, the stop line rises one ready-to-pause interval later, and the acknowledge is released once the device has withdrawn its request. The device can also end the burst by withdrawing its request. All intervals are counted in clock cycles from nanosecond values rounded up, with the clock period as a parameter. Modes 0 to 4 can be selected. The strobe and the request pass through two-flop synchronisers.

Top module: `udma_rx_host`

## Requirements
- R1: While reset is held and after its release, host_ack and host_ready are low, host_stop is high, and out_valid and sender_paused are low.
- R2: Once a request is seen in idle, host_ack rises. Exactly ENV cycles later (ENV = ceil(20 ns / clock period)), host_stop falls and host_ready rises in the same cycle. host_ready is never high unless host_ack is high and host_stop is low.
- R3: Each toggle of dev_strobe, in either direction, while host_ack is high delivers exactly one word on the output stream. The word is the dev_data value present with the toggle, and words come out in arrival order.
- R4: A strobe toggle while host_ack is low adds nothing to the output stream.
- R5: host_ready falls when the internal store has fewer than THRESH free slots. The word waiting in the output register does not count as occupying a slot. With the stream stalled from empty, ready stays high after DEPTH-THRESH+1 words and falls after DEPTH-THRESH+2.
- R6: sender_paused rises exactly RP cycles after host_ready falls. RP = ceil(t / clock period), with t = 160, 125, 100, 100, 100 ns for modes 0..4. sender_paused is never high together with host_ready.
- R7: Words whose strobe edges arrive after host_ready has fallen, including during the pause interval, are still accepted in order.
- R8: While paused, host_ready rises again as soon as THRESH slots are free, and sender_paused clears in that same cycle.
- R9: A one-cycle end_req during a burst drops host_ready in the next cycle. host_stop rises RP cycles after host_ready fell. host_ack stays high until the request is withdrawn, then falls ENV+2 cycles after the first clock edge that samples dev_req low, with host_stop still high.
- R10: If dev_req is withdrawn during a burst, host_stop rises and host_ready is low in the same cycle, and host_ack falls exactly ENV cycles after host_stop rises.
- R11: mode_sel values 5 to 7 give the mode-4 timing.
- R12: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Timing mode, 0..4 (higher values act as 4) |
| end_req | input | 1 | One-cycle request to close the burst |
| dev_req | input | 1 | Device DMA request, asynchronous |
| dev_strobe | input | 1 | Device data strobe, asynchronous; each toggle is one word |
| dev_data | input | W | Device data bus |
| host_ack | output | 1 | DMA acknowledge, active high |
| host_stop | output | 1 | Stop line, active high |
| host_ready | output | 1 | Host ready to receive, active high |
| sender_paused | output | 1 | Ready-to-pause interval has expired since ready fell |
| out_valid | output | 1 | Output word available |
| out_data | output | W | Output word |
| out_ready | input | 1 | Consumer accepts the output word |

## Verification
The interesting overlap is a strobe word landing in the same window in which the ready line is being withdrawn. The bench stalls the stream until the ready line drops. While the pause counter is running, it fires two more strobe toggles, at fixed cycle offsets after the drop. It then judges two things: that the pause flag still rises exactly RP cycles after ready fell, and that both late words later appear in order on the stream. A second overlap is the release of the stall with a pause in progress. There the bench checks that ready rises and the pause flag clears in the same sampled cycle. Each mode from 0 to 7 is swept, alternating host-ended and device-ended bursts, with all expected intervals computed from the nanosecond table.

// File: rtl/udma_rx_pkg.sv
package udma_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_DRAIN,
    ST_STOPPING,
    ST_RELEASE
  } rx_state_t;

  // minimum spacing of control edges inside the acknowledge envelope
  localparam int unsigned ENVELOPE_NS = 20;

  // interval after ready withdrawal before the sender may be taken as paused
  function automatic int unsigned pause_ns(input logic [2:0] m);
    case (m)
      3'd0:    return 160;
      3'd1:    return 125;
      default: return 100;
    endcase
  endfunction

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/udma_rx_sync.sv
module udma_rx_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe_in,
  input  logic         req_in,
  input  logic [W-1:0] data_in,
  output logic         cap,
  output logic [W-1:0] cap_data,
  output logic         req_s
);

  logic [2:0]   st;
  logic [1:0]   rq;
  logic [W-1:0] d1, d2;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
      rq <= '0;
    end else begin
      st <= {st[1:0], strobe_in};
      rq <= {rq[0], req_in};
    end
  end

  // data travels the same two stages as the strobe so the pair stays aligned
  always_ff @(posedge clk) begin
    d1 <= data_in;
    d2 <= d1;
  end

  assign cap      = st[1] ^ st[2];
  assign cap_data = d2;
  assign req_s    = rq[1];

endmodule

// File: rtl/udma_rx_fifo.sv
module udma_rx_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [W-1:0]             wr_data,
  output logic                     out_valid,
  output logic [W-1:0]             out_data,
  input  logic                     out_ready,
  output logic [$clog2(DEPTH):0]   free_slots
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt;
  logic          wr_ok, load;

  assign wr_ok = wr_en && (cnt != FULL);
  assign load  = (!out_valid || out_ready) && (cnt != '0);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (load) out_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
      if (load)  rd_ptr <= rd_ptr + 1'b1;
      case ({wr_ok, load})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (load)           out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  assign free_slots = FULL - cnt;

endmodule

// File: rtl/udma_rx_ctrl.sv
module udma_rx_ctrl
  import udma_rx_pkg::*;
#(
  parameter int unsigned CLK_NS = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic       req_s,
  input  logic       end_req,
  input  logic       room_ok,
  output logic       ack,
  output logic       stop,
  output logic       ready,
  output logic       paused
);

  localparam int unsigned ENV_CYC = ns_to_cyc(ENVELOPE_NS, CLK_NS);
  localparam int unsigned RP_MAX  = ns_to_cyc(pause_ns(3'd0), CLK_NS);
  localparam int unsigned TOP_CYC = (RP_MAX > ENV_CYC) ? RP_MAX : ENV_CYC;
  localparam int unsigned CW      = $clog2(TOP_CYC + 1);
  localparam logic [CW-1:0] ENV_LD = CW'(ENV_CYC);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [CW-1:0] rp_tab [8];
  logic [CW-1:0] rp_cyc;

  for (genvar g = 0; g < 8; g++) begin : g_rp
    assign rp_tab[g] = CW'(ns_to_cyc(pause_ns(3'(g)), CLK_NS));
  end

  assign rp_cyc = rp_tab[mode];

  rx_state_t     state;
  logic [CW-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      wcnt   <= '0;
      ack    <= 1'b0;
      stop   <= 1'b1;
      ready  <= 1'b0;
      paused <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_s) begin
            ack   <= 1'b1;
            wcnt  <= ENV_LD;
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (wcnt == ONE) begin
            stop  <= 1'b0;
            ready <= 1'b1;
            state <= ST_XFER;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        ST_XFER: begin
          if (!req_s) begin
            stop   <= 1'b1;
            ready  <= 1'b0;
            paused <= 1'b0;
            wcnt   <= ENV_LD;
            state  <= ST_RELEASE;
          end else if (end_req) begin
            ready  <= 1'b0;
            paused <= 1'b0;
            wcnt   <= rp_cyc;
            state  <= ST_DRAIN;
          end else if (ready && !room_ok) begin
            ready <= 1'b0;
            wcnt  <= rp_cyc;
          end else if (!ready && room_ok) begin
            ready  <= 1'b1;
            paused <= 1'b0;
          end else if (!ready && !paused) begin
            if (wcnt == ONE) paused <= 1'b1;
            wcnt <= wcnt - 1'b1;
          end
        end
        ST_DRAIN: begin
          if (!req_s) begin
            stop  <= 1'b1;
            wcnt  <= ENV_LD;
            state <= ST_RELEASE;
          end else if (wcnt == ONE) begin
            stop  <= 1'b1;
            state <= ST_STOPPING;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        ST_STOPPING: begin
          if (!req_s) begin
            wcnt  <= ENV_LD;
            state <= ST_RELEASE;
          end
        end
        ST_RELEASE: begin
          if (wcnt == ONE) begin
            ack   <= 1'b0;
            state <= ST_IDLE;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/udma_rx_host.sv
module udma_rx_host #(
  parameter int unsigned W      = 16,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned THRESH = 4,
  parameter int unsigned CLK_NS = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   mode_sel,
  input  logic         end_req,
  input  logic         dev_req,
  input  logic         dev_strobe,
  input  logic [W-1:0] dev_data,
  output logic         host_ack,
  output logic         host_stop,
  output logic         host_ready,
  output logic         sender_paused,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);

  localparam int unsigned AW = $clog2(DEPTH);

  logic         cap, req_s, room_ok;
  logic [W-1:0] cap_data;
  logic [AW:0]  free_slots;

  udma_rx_sync #(.W(W)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .strobe_in(dev_strobe),
    .req_in   (dev_req),
    .data_in  (dev_data),
    .cap      (cap),
    .cap_data (cap_data),
    .req_s    (req_s)
  );

  udma_rx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cap && host_ack),
    .wr_data   (cap_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .free_slots(free_slots)
  );

  assign room_ok = (free_slots >= (AW+1)'(THRESH));

  udma_rx_ctrl #(.CLK_NS(CLK_NS)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode_sel),
    .req_s  (req_s),
    .end_req(end_req),
    .room_ok(room_ok),
    .ack    (host_ack),
    .stop   (host_stop),
    .ready  (host_ready),
    .paused (sender_paused)
  );

endmodule

// File: rtl/udma_rx_host_chk.sv
module udma_rx_host_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         host_ack,
  input logic         host_stop,
  input logic         host_ready,
  input logic         sender_paused,
  input logic         out_valid,
  input logic [W-1:0] out_data,
  input logic         out_ready
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!host_ack && host_stop && !host_ready && !out_valid && !sender_paused));

  // R2
  ready_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> (host_ack && !host_stop));

  // R2
  stop_open_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(host_stop) |-> host_ack);

  // R6
  pause_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sender_paused |-> !host_ready);

  // R9
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(host_ack) |-> host_stop);

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind udma_rx_host udma_rx_host_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .host_ack     (host_ack),
  .host_stop    (host_stop),
  .host_ready   (host_ready),
  .sender_paused(sender_paused),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .out_ready    (out_ready)
);

// File: tb/sim_udma_rx_host.sv
module sim_udma_rx_host;
  localparam int W = 16, DEPTH = 8, THRESH = 3, CLK_NS = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] mode_sel = '0;
  logic end_req = 1'b0, dev_req = 1'b0, dev_strobe = 1'b0, out_ready = 1'b0;
  logic [W-1:0] dev_data = '0;
  logic host_ack, host_stop, host_ready, sender_paused, out_valid;
  logic [W-1:0] out_data;

  udma_rx_host #(.W(W), .DEPTH(DEPTH), .THRESH(THRESH), .CLK_NS(CLK_NS)) u0 (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .end_req(end_req), .dev_req(dev_req),
    .dev_strobe(dev_strobe), .dev_data(dev_data), .host_ack(host_ack), .host_stop(host_stop),
    .host_ready(host_ready), .sender_paused(sender_paused), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  int exp_n = 0, rx_n = 0, cmp_i = 0;
  logic [W-1:0] exp_mem [0:511];
  logic [W-1:0] rx_mem  [0:511];
  int env_c = (20 + CLK_NS - 1) / CLK_NS;

  function automatic int rp_exp(input int m);
    int ns;
    ns = (m == 0) ? 160 : (m == 1) ? 125 : 100;
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put_word(input int v, input bit keep);
    dev_data   = v[W-1:0];
    dev_strobe = ~dev_strobe;
    if (keep) begin
      exp_mem[exp_n] = v[W-1:0];
      exp_n++;
    end
  endtask

  task automatic set_oready(input logic v);
    @(posedge clk);
    #1 out_ready = v;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      rx_mem[rx_n] = out_data;
      rx_n++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog all-requirements actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int m = 0; m < 8; m++) begin
      int c;
      int first_pause;
      mode_sel = 3'(m);
      @(negedge clk);
      rst = 1'b1; end_req = 1'b0; dev_req = 1'b0;
      set_oready(1'b0);
      repeat (3) @(negedge clk);
      // R1 reset state while held
      check_eq("R1 ack in reset", int'(host_ack), 0);
      check_eq("R1 stop in reset", int'(host_stop), 1);
      check_eq("R1 ready in reset", int'(host_ready), 0);
      check_eq("R1 valid in reset", int'(out_valid), 0);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      check_eq("R1 ack after reset", int'(host_ack), 0);
      check_eq("R1 paused after reset", int'(sender_paused), 0);
      set_oready(1'b1);

      // R4 strobe toggles without acknowledge
      @(negedge clk);
      put_word(16'hdead, 1'b0);
      repeat (4) @(negedge clk);
      put_word(16'hbeef, 1'b0);
      repeat (8) @(negedge clk);
      check_eq("R4 ignored words", rx_n, exp_n);

      // R2 burst opening
      dev_req = 1'b1;
      c = 0;
      while (!host_ack && c < 20) begin @(negedge clk); c++; end
      check_eq("R2 ack rises", int'(host_ack), 1);
      check_eq("R2 stop held during envelope", int'(host_stop), 1);
      c = 0;
      while (host_stop && c < 20) begin @(negedge clk); c++; end
      check_eq("R2 envelope cycles", c, env_c);
      check_eq("R2 ready with stop fall", int'(host_ready), 1);

      // R3 streamed words, alternating strobe directions
      for (int k = 0; k < 4; k++) begin
        put_word(m * 256 + k, 1'b1);
        repeat (6) @(negedge clk);
      end

      // R5 fill to the pause threshold with the stream stalled
      repeat (4) @(negedge clk);
      set_oready(1'b0);
      @(negedge clk);
      first_pause = m * 256 + 16;
      for (int k = 0; k < DEPTH - THRESH + 1; k++) begin
        put_word(first_pause + k, 1'b1);
        repeat (6) @(negedge clk);
      end
      check_eq("R5 ready high below threshold", int'(host_ready), 1);
      put_word(first_pause + DEPTH - THRESH + 1, 1'b1);
      c = 0;
      while (host_ready && c < 20) begin @(negedge clk); c++; end
      check_eq("R5 ready falls at threshold", int'(host_ready), 0);

      // R6 / R7 pause window with late words
      c = 0;
      while (!sender_paused && c < 40) begin
        @(negedge clk);
        c++;
        if (c == 2) put_word(first_pause + 40, 1'b1);
        if (c == 5) put_word(first_pause + 41, 1'b1);
      end
      check_eq((m > 4) ? "R11 pause interval clamped" : "R6 pause interval", c, rp_exp(m));
      // R12 stalled output holds
      check_eq("R12 held word", int'(out_data), first_pause);
      repeat (3) @(negedge clk);
      check_eq("R12 held word later", int'(out_data), first_pause);
      check_eq("R12 held valid", int'(out_valid), 1);

      // R8 resume
      set_oready(1'b1);
      c = 0;
      while (!host_ready && c < 40) begin @(negedge clk); c++; end
      check_eq("R8 ready resumes", int'(host_ready), 1);
      check_eq("R8 paused clears with ready", int'(sender_paused), 0);
      repeat (20) @(negedge clk);

      if (m % 2 == 0) begin
        // R9 host-ended burst
        end_req = 1'b1;
        @(negedge clk);
        end_req = 1'b0;
        check_eq("R9 ready drops", int'(host_ready), 0);
        c = 0;
        while (!host_stop && c < 40) begin @(negedge clk); c++; end
        check_eq("R9 stop after pause interval", c, rp_exp(m));
        repeat (4) @(negedge clk);
        check_eq("R9 ack held until request drops", int'(host_ack), 1);
        dev_req = 1'b0;
        c = 0;
        while (host_ack && c < 40) begin @(negedge clk); c++; end
        check_eq("R9 ack release cycles", c, env_c + 3);
        check_eq("R9 stop high at release", int'(host_stop), 1);
      end else begin
        // R10 device-ended burst
        dev_req = 1'b0;
        c = 0;
        while (!host_stop && c < 20) begin @(negedge clk); c++; end
        check_eq("R10 stop rises", int'(host_stop), 1);
        check_eq("R10 ready low with stop", int'(host_ready), 0);
        c = 0;
        while (host_ack && c < 20) begin @(negedge clk); c++; end
        check_eq("R10 ack after stop", c, env_c);
      end

      repeat (10) @(negedge clk);
      // R3 / R7 order and content
      check_eq("R3 word count", rx_n, exp_n);
      for (int i = cmp_i; i < exp_n && i < rx_n; i++)
        check_eq((i >= cmp_i + 4) ? "R7 late word" : "R3 word", int'(rx_mem[i]), int'(exp_mem[i]));
      cmp_i = exp_n;
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule